// File: doc/BRIEF.md
# Fault Trigger Qualifier

This block watches for a fault condition on behalf of a PWM timer. One of two asynchronous fault lines is chosen: a general-purpose external pin, or the output of an analog comparator. The chosen line is brought into the system clock domain by a two-flop synchroniser. It can then pass through a digital filter, which lets its level change only after four consecutive samples agree. A programmable edge detector follows the filter. When protection is armed and the chosen edge arrives, the block raises a fault strobe for one cycle. In the same clock edge it disarms itself and sets a sticky fault flag.

The timer clears its compare-output modes on the clock edge that ends the strobe cycle. That is the same edge on which the arm bit drops, so software can see that fault mode was entered by polling the arm bit. It can also enable the interrupt line, which follows the flag. Changing the source, the edge polarity or the arm bit can itself look like an edge. Software is therefore expected to clear the flag after any such change. The filter always runs on the undivided system clock.

Top module: `fault_guard`

## Requirements
- R1: `src_cmp_i` = 0 selects `ext_pin_i` and 1 selects `cmp_out_i`. While one line is selected, activity on the other causes no strobe and leaves the flag and arm bit unchanged.
- R2: With the filter off, a change on the selected line set up before rising edge N shows on `fault_strobe_o` during the cycle that follows rising edge N+1.
- R3: With `filt_en_i` = 1, that same change reaches `fault_strobe_o` exactly four clock cycles later than in R2.
- R4: With the filter on, a pulse on the selected line that lasts fewer than four clock cycles is rejected: no strobe, and the flag and arm bit are unchanged.
- R5: `edge_rise_i` = 1 qualifies a low-to-high transition and 0 qualifies a high-to-low transition. The opposite transition causes no strobe.
- R6: A qualifying edge raises `fault_strobe_o` only while `prot_en_o` = 1, and the strobe lasts one cycle.
- R7: The clock edge that ends a strobe cycle clears `prot_en_o`. A write to the arm bit (`prot_en_we_i` with `prot_en_wd_i`) in the strobe cycle loses to the fault.
- R8: A strobe sets `flag_o`, which stays set until `flag_clr_i` = 1 (write-one-to-clear). A strobe in the same cycle as a clear leaves the flag set.
- R9: `irq_o` is `flag_o` AND `irq_en_i`. With `irq_en_i` = 0 the fault can still be seen because `prot_en_o` reads 0.
- R10: During and straight after synchronous active-low reset, `prot_en_o`, `flag_o`, `fault_strobe_o` and `irq_o` are 0.
- R11: Switching `src_cmp_i` while armed, when the two lines differ in the qualifying direction, produces a fault. A flag clear issued after the switch then leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 1 | Asynchronous external fault pin |
| cmp_out_i | input | 1 | Asynchronous analog comparator output |
| src_cmp_i | input | 1 | Source select: 0 pin, 1 comparator |
| filt_en_i | input | 1 | Enable the four-sample agreement filter |
| edge_rise_i | input | 1 | Edge polarity: 1 rising, 0 falling |
| irq_en_i | input | 1 | Interrupt enable |
| prot_en_we_i | input | 1 | Write strobe for the arm bit |
| prot_en_wd_i | input | 1 | Value written to the arm bit |
| flag_clr_i | input | 1 | Write-one-to-clear for the fault flag |
| prot_en_o | output | 1 | Arm bit; drops when a fault is taken |
| flag_o | output | 1 | Sticky fault flag |
| fault_strobe_o | output | 1 | One-cycle fault pulse to the timer |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in one cycle. A fault strobe can coincide with a software clear of the flag, and it can coincide with a software write that re-arms protection. The bench provokes each pair by driving the write on the falling edge inside the cycle where the strobe is high. It then judges the result on the next falling edge: the flag must stay at 1 and the arm bit must read 0. The bench also checks that a clear issued alone, one cycle later, does take effect, so a design that ignores clears cannot pass the collision test.

// File: rtl/fault_guard_pkg.sv
// Package: fault_guard_pkg
// Shared constants and encodings for the fault trigger qualifier.
// Assumes: the depth values are small, fixed implementation choices.
package fault_guard_pkg;
    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned FILT_DEPTH_DEF  = 4;

    typedef enum logic { SRC_PIN = 1'b0, SRC_CMP = 1'b1 } fault_src_e;
    typedef enum logic { EDGE_FALL = 1'b0, EDGE_RISE = 1'b1 } edge_pol_e;
endpackage

// File: rtl/fg_sync.sv
// Module: fg_sync
// Multi-flop synchroniser that brings an asynchronous level into the clk domain.
// Assumes: the input is a slow level; metastability settles within one stage.
module fg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fg_filter.sv
// Module: fg_filter
// Agreement filter: its output follows the input only once DEPTH consecutive
// samples are equal. Adds exactly DEPTH cycles of latency to a clean change.
// Assumes: DEPTH >= 2; it runs every cycle of the undivided clock.
module fg_filter #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic filt_o
);
    localparam int unsigned CW = $clog2(DEPTH) + 1;

    logic [DEPTH-1:0] samp_q;
    logic             hold_q;
    logic             all_one;
    logic             all_zero;

    // Shift one new sample per clock into the sample window.
    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= '0;
        else        samp_q <= {samp_q[DEPTH-2:0], din_i};
    end

    assign all_one  = &samp_q;
    assign all_zero = ~|samp_q;

    // Output moves only when the whole window agrees, otherwise it holds.
    always_comb begin
        if (all_one)       filt_o = 1'b1;
        else if (all_zero) filt_o = 1'b0;
        else               filt_o = hold_q;
    end

    // Remember the last accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= filt_o;
    end

    // Checker state: cycles since the filtered level last moved.
    logic [CW-1:0] since_q;
    logic          seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (filt_o != hold_q) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q < CW'(DEPTH)) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_FILT_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (filt_o != hold_q)) |-> (since_q >= CW'(DEPTH - 1))); // R4
endmodule

// File: rtl/fg_edge.sv
// Module: fg_edge
// Edge detector with selectable polarity; compares the current level with
// the level registered on the previous clock.
// Assumes: level_i is already synchronous to clk.
module fg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic rise_i,
    output logic edge_o
);
    import fault_guard_pkg::*;

    logic prev_q;

    // Keep the previous level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    // Qualify the transition against the selected polarity.
    always_comb begin
        if (rise_i == EDGE_RISE) edge_o = level_i & ~prev_q;
        else                     edge_o = ~level_i & prev_q;
    end

    AST_EDGE_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !(edge_o && $stable(rise_i))); // R5
endmodule

// File: rtl/fault_guard.sv
// Module: fault_guard
// Fault trigger qualifier: source select, synchroniser, optional agreement
// filter and edge detector, followed by the arm bit, sticky flag and
// interrupt request. The strobe is one cycle wide, and the timer clears its
// compare-output modes on the same edge that clears the arm bit.
// Assumes: the control inputs come from registers in the clk domain.
module fault_guard
    import fault_guard_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    parameter int unsigned FILT_DEPTH  = FILT_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin_i,
    input  logic cmp_out_i,
    input  logic src_cmp_i,
    input  logic filt_en_i,
    input  logic edge_rise_i,
    input  logic irq_en_i,
    input  logic prot_en_we_i,
    input  logic prot_en_wd_i,
    input  logic flag_clr_i,
    output logic prot_en_o,
    output logic flag_o,
    output logic fault_strobe_o,
    output logic irq_o
);
    logic src_level;
    logic sync_level;
    logic filt_level;
    logic det_level;
    logic edge_hit;
    logic prot_en_q;
    logic flag_q;

    // Pick the fault source before it enters the clock domain.
    always_comb begin
        if (src_cmp_i == SRC_CMP) src_level = cmp_out_i;
        else                      src_level = ext_pin_i;
    end

    fg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_level),
        .sync_o  (sync_level)
    );

    fg_filter #(.DEPTH(FILT_DEPTH)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (sync_level),
        .filt_o (filt_level)
    );

    // Bypass the filter when it is disabled.
    always_comb begin
        det_level = filt_en_i ? filt_level : sync_level;
    end

    fg_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (det_level),
        .rise_i  (edge_rise_i),
        .edge_o  (edge_hit)
    );

    assign fault_strobe_o = edge_hit & prot_en_q;

    // Arm bit: software write, overridden by a fault in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)              prot_en_q <= 1'b0;
        else if (fault_strobe_o) prot_en_q <= 1'b0;
        else if (prot_en_we_i)   prot_en_q <= prot_en_wd_i;
    end

    // Sticky flag: set by a fault, which beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (fault_strobe_o) flag_q <= 1'b1;
        else if (flag_clr_i)     flag_q <= 1'b0;
    end

    assign prot_en_o = prot_en_q;
    assign flag_o    = flag_q;
    assign irq_o     = flag_q & irq_en_i;

    AST_FAULT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_strobe_o |=> !prot_en_o); // R7
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_strobe_o |=> !fault_strobe_o); // R6
    AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault_strobe_o |=> flag_o); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !fault_strobe_o) |=> !flag_o); // R8
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_strobe_o && irq_en_i) |=> (irq_o || !irq_en_i)); // R9
endmodule

// File: tb/fault_guard_tb.sv
module fault_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pin_i = 1'b0, cmp_out_i = 1'b0, src_cmp_i = 1'b0, filt_en_i = 1'b0;
    logic edge_rise_i = 1'b1, irq_en_i = 1'b0, prot_en_we_i = 1'b0, prot_en_wd_i = 1'b0;
    logic flag_clr_i = 1'b0;
    logic prot_en_o, flag_o, fault_strobe_o, irq_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    fault_guard u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i), .cmp_out_i(cmp_out_i),
        .src_cmp_i(src_cmp_i), .filt_en_i(filt_en_i), .edge_rise_i(edge_rise_i),
        .irq_en_i(irq_en_i), .prot_en_we_i(prot_en_we_i), .prot_en_wd_i(prot_en_wd_i),
        .flag_clr_i(flag_clr_i), .prot_en_o(prot_en_o), .flag_o(flag_o),
        .fault_strobe_o(fault_strobe_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {src, rise, pin0, cmp0, pin1, cmp1, expect_fault}
    localparam int NVEC = 8;
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0_1_00_10_1,   // R1 R5 pin rises
        7'b0_1_10_00_0,   // R5 pin falls, rising selected
        7'b0_0_10_00_1,   // R5 pin falls, falling selected
        7'b0_1_00_01_0,   // R1 comparator moves while pin selected
        7'b1_1_00_01_1,   // R1 comparator rises
        7'b1_0_01_10_1,   // R1 R5 comparator falls
        7'b1_1_00_10_0,   // R1 pin moves while comparator selected
        7'b1_0_00_01_0    // R5 comparator rises, falling selected
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Disarm, settle the baseline levels, then arm with a clean flag.
    task automatic setup(input logic src, input logic rise, input logic filt,
                         input logic p0, input logic c0);
        prot_en_we_i = 1'b1; prot_en_wd_i = 1'b0;
        src_cmp_i = src; edge_rise_i = rise; filt_en_i = filt;
        ext_pin_i = p0; cmp_out_i = c0;
        tick(10);
        prot_en_wd_i = 1'b1; flag_clr_i = 1'b1;
        tick(1);
        prot_en_we_i = 1'b0; flag_clr_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(3);
        chk("R10 prot_en in reset", prot_en_o, 1'b0);
        chk("R10 flag in reset", flag_o, 1'b0);
        chk("R10 strobe in reset", fault_strobe_o, 1'b0);
        rst_n = 1'b1;
        tick(1);
        chk("R10 irq after reset", irq_o, 1'b0);
        chk("R10 prot_en after reset", prot_en_o, 1'b0);

        // Table walk, filter off
        for (int i = 0; i < NVEC; i++) begin
            setup(VEC[i][6], VEC[i][5], 1'b0, VEC[i][4], VEC[i][3]);
            ext_pin_i = VEC[i][2]; cmp_out_i = VEC[i][1];
            tick(2);
            chk("R2 R1 R5 strobe", fault_strobe_o, VEC[i][0]);
            tick(1);
            chk("R6 strobe one cycle", fault_strobe_o, 1'b0);
            chk("R8 flag", flag_o, VEC[i][0]);
            chk("R7 prot_en", prot_en_o, ~VEC[i][0]);
        end

        // R3: filter adds exactly four cycles
        setup(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        ext_pin_i = 1'b1;
        tick(5);
        chk("R3 no strobe one cycle early", fault_strobe_o, 1'b0);
        tick(1);
        chk("R3 strobe after four extra cycles", fault_strobe_o, 1'b1);

        // R4: three-cycle pulse rejected by the filter
        setup(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        ext_pin_i = 1'b1;
        tick(3);
        ext_pin_i = 1'b0;
        tick(12);
        chk("R4 short pulse flag", flag_o, 1'b0);
        chk("R4 short pulse prot_en", prot_en_o, 1'b1);

        // R6: edge while disarmed
        setup(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        prot_en_we_i = 1'b1; prot_en_wd_i = 1'b0;
        tick(1);
        prot_en_we_i = 1'b0;
        ext_pin_i = 1'b1;
        tick(2);
        chk("R6 no strobe when disarmed", fault_strobe_o, 1'b0);
        tick(1);
        chk("R6 no flag when disarmed", flag_o, 1'b0);

        // R7: re-arm write in the strobe cycle loses
        setup(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        ext_pin_i = 1'b1;
        tick(2);
        chk("R7 strobe", fault_strobe_o, 1'b1);
        prot_en_we_i = 1'b1; prot_en_wd_i = 1'b1;
        tick(1);
        prot_en_we_i = 1'b0;
        chk("R7 fault beats arm write", prot_en_o, 1'b0);

        // R8: clear in the strobe cycle loses; R9 interrupt and polling
        irq_en_i = 1'b0;
        setup(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        ext_pin_i = 1'b1;
        tick(2);
        chk("R8 strobe", fault_strobe_o, 1'b1);
        flag_clr_i = 1'b1;
        tick(1);
        flag_clr_i = 1'b0;
        chk("R8 fault beats clear", flag_o, 1'b1);
        chk("R9 irq masked", irq_o, 1'b0);
        chk("R9 poll arm bit", prot_en_o, 1'b0);
        irq_en_i = 1'b1;
        #1;
        chk("R9 irq enabled", irq_o, 1'b1);
        flag_clr_i = 1'b1;
        tick(1);
        flag_clr_i = 1'b0;
        chk("R8 clear alone", flag_o, 1'b0);
        chk("R9 irq drops", irq_o, 1'b0);
        irq_en_i = 1'b0;

        // R11: source switch triggers, later clear holds
        setup(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        src_cmp_i = 1'b1;
        tick(2);
        chk("R11 switch strobe", fault_strobe_o, 1'b1);
        tick(1);
        chk("R11 switch flag", flag_o, 1'b1);
        flag_clr_i = 1'b1;
        tick(1);
        flag_clr_i = 1'b0;
        chk("R11 clear after switch", flag_o, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule